// File: doc/BRIEF.md
# Masked Dual Time-of-Day Alarm Interrupt Unit

This block keeps two independent time-of-day alarms and turns their matches into interrupt requests. Each alarm holds four byte registers (seconds, minutes, hours, day of week). Bit 7 of each register is a "don't care" mask for that field, and bits 6:0 hold the value compared against the current time. The time counters and the serial access logic sit outside the block. They supply the present time, a one-cycle clock-update strobe, and a register-access port that carries the address pointer of every read or write byte.

When the update strobe arrives and every unmasked field of an alarm equals the current time, that alarm's request flag is set. Alarm 0 drives an active-low level interrupt that stays asserted while its flag and enable are both 1. Alarm 1 drives an active-high pulse of fixed length, counted in periods of a 32.768 kHz enable. A flag is cleared whenever the access pointer lands on one of that alarm's registers, for a read or for a write. Masking fields from day upward gives weekly, daily, hourly, per-minute and per-second repeat.

Top module: `dual_alarm_irq`

## Requirements
- R1: An access with address bit 7 set and bits 6:0 in 07h..0Ah (alarm 0) or 0Bh..0Eh (alarm 1) loads the data byte into that alarm's register. The offset from the alarm base selects the field: +0 seconds, +1 minutes, +2 hours, +3 day.
- R2: A field matches when its register bit 7 is 1 (masked) or when register bits 6:0 equal the current time field bits 6:0. An alarm matches when all four fields match.
- R3: A flag is set only on a cycle with the update strobe high and its alarm matching. Without the strobe, a standing match sets nothing. The status byte carries flag 0 in bit 0 and flag 1 in bit 1, and bits 7:2 are always 0.
- R4: An access whose address bits 6:0 fall in an alarm's range clears that alarm's flag, whether address bit 7 is 0 (read) or 1 (write). Accesses to the other alarm or to other addresses leave the flag unchanged.
- R5: When a set and a clear of the same flag occur in one cycle, the flag ends up set.
- R6: The output irq0_n is 0 exactly when flag 0 and enable bit 0 are both 1, and is 1 otherwise.
- R7: A setting of flag 1 while enable bit 1 is 1 starts a pulse on irq1. The pulse lasts exactly PULSE_TICKS assertions of the 32.768 kHz enable that follow its start.
- R8: A new setting of flag 1 during a running pulse neither restarts nor extends it.
- R9: While enable bit 1 is 0, irq1 is 0, and a flag 1 setting in that state starts no pulse.
- R10: After reset both flags are 0, irq0_n is 1, irq1 is 0, and all alarm registers are 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_stb | input | 1 | One-cycle clock-update strobe from the time counters |
| tick_32k | input | 1 | One-cycle enable at 32.768 kHz rate |
| now_sec | input | 8 | Current seconds (BCD) |
| now_min | input | 8 | Current minutes (BCD) |
| now_hour | input | 8 | Current hours, including 12/24 and AM/PM bits |
| now_day | input | 8 | Current day of week |
| acc_valid | input | 1 | Address pointer valid for one byte access |
| acc_addr | input | 8 | Access address; bit 7 = 1 for write |
| acc_data | input | 8 | Write data |
| irq_en | input | 2 | Interrupt enables: bit 0 alarm 0, bit 1 alarm 1 |
| status | output | 8 | Flag byte: bit 0 flag 0, bit 1 flag 1, rest 0 |
| irq0_n | output | 1 | Active-low level interrupt for alarm 0 |
| irq1 | output | 1 | Active-high fixed-length pulse for alarm 1 |

## Verification
Several properties are checked on every cycle: flags rise only after a strobe, a pointer touch without a coincident set clears the flag, the set-over-clear priority holds, irq0_n is low only with flag 0 and its enable, irq1 is low whenever its enable is low, and the pulse counter never passes its limit or restarts while it runs. The meaning of each mask pattern is shown only by the bench's vectors: daily, hourly, per-minute and per-second repeat, and the 12/24-hour bit taking part in the comparison. The same holds for the exact pulse length in tick periods, for a mid-pulse re-match having no effect, and for an access to the other alarm's range leaving a flag untouched.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    localparam int NUM_ALARMS  = 2;
    localparam int NUM_FIELDS  = 4;
    localparam int BYTE_W      = 8;
    localparam int FIELD_AW    = $clog2(NUM_FIELDS);

    // base of each alarm's register window (address bits 6:0)
    localparam logic [6:0] ALARM0_BASE = 7'h07;
    localparam logic [6:0] ALARM1_BASE = 7'h0B;

    typedef enum logic [FIELD_AW-1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2,
        FLD_DAY  = 2'd3
    } field_e;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] day;
    } tod_t;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } access_t;

    // a masked field always matches; otherwise the seven value bits must agree
    function automatic logic field_hit(input logic [BYTE_W-1:0] alarm_v,
                                       input logic [BYTE_W-1:0] time_v);
        return alarm_v[BYTE_W-1] | (alarm_v[BYTE_W-2:0] == time_v[BYTE_W-2:0]);
    endfunction

    function automatic logic in_window(input logic [6:0] a, input logic [6:0] base);
        return (a >= base) && (a < base + 7'(NUM_FIELDS));
    endfunction

endpackage

// File: rtl/alarm_slot.sv
module alarm_slot
    import alarm_pkg::*;
#(
    parameter logic [6:0] BASE = ALARM0_BASE
) (
    input  logic    clk,
    input  logic    rst,
    input  access_t acc,
    input  tod_t    now,
    output logic    hit,
    output logic    touched
);

    logic [BYTE_W-1:0] regs [NUM_FIELDS];
    logic [6:0]        offs;
    logic [FIELD_AW-1:0] sel;

    assign touched = acc.valid && in_window(acc.addr[6:0], BASE);
    assign offs    = acc.addr[6:0] - BASE;
    assign sel     = offs[FIELD_AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_FIELDS; i++) regs[i] <= '0;
        end else if (touched && acc.addr[7]) begin
            regs[sel] <= acc.data;
        end
    end

    assign hit = field_hit(regs[FLD_SEC],  now.sec)
              && field_hit(regs[FLD_MIN],  now.min)
              && field_hit(regs[FLD_HOUR], now.hour)
              && field_hit(regs[FLD_DAY],  now.day);

endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
    input  logic clk,
    input  logic rst,
    input  logic upd_stb,
    input  logic hit,
    input  logic touched,
    output logic set_evt,
    output logic flag
);

    assign set_evt = upd_stb && hit;

    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (touched) flag <= 1'b0;
    end

    // R3: a flag only rises after an update strobe
    p_set_on_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(upd_stb));

    // R4: a pointer touch with no coincident set leaves the flag clear
    p_touch_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (touched && !(upd_stb && hit)) |=> !flag);

    // R5: a set wins over a clear in the same cycle
    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (upd_stb && hit && touched) |=> flag);

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
    parameter int TICKS = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    output logic active
);

    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                cnt    <= '0;
            end
        end else if (tick) begin
            if (cnt == LAST) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R7: the tick count never passes its limit
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R8: a running pulse is neither restarted nor cut short before its last tick
    p_no_retrigger_r8: assert property (@(posedge clk) disable iff (rst)
        (active && !(tick && cnt == LAST)) |=> (active && cnt >= $past(cnt)));

endmodule

// File: rtl/dual_alarm_irq.sv
module dual_alarm_irq
    import alarm_pkg::*;
#(
    parameter int PULSE_TICKS = 2048
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       upd_stb,
    input  logic       tick_32k,
    input  logic [7:0] now_sec,
    input  logic [7:0] now_min,
    input  logic [7:0] now_hour,
    input  logic [7:0] now_day,
    input  logic       acc_valid,
    input  logic [7:0] acc_addr,
    input  logic [7:0] acc_data,
    input  logic [1:0] irq_en,
    output logic [7:0] status,
    output logic       irq0_n,
    output logic       irq1
);

    localparam logic [6:0] BASES [NUM_ALARMS] = '{ALARM0_BASE, ALARM1_BASE};

    tod_t    now;
    access_t acc;
    logic [NUM_ALARMS-1:0] hit, touched, set_evt, flag;
    logic pulse_on;

    assign now = '{sec: now_sec, min: now_min, hour: now_hour, day: now_day};
    assign acc = '{valid: acc_valid, addr: acc_addr, data: acc_data};

    for (genvar k = 0; k < NUM_ALARMS; k++) begin : g_alarm
        alarm_slot #(.BASE(BASES[k])) u_slot (
            .clk(clk), .rst(rst), .acc(acc), .now(now),
            .hit(hit[k]), .touched(touched[k])
        );
        alarm_flag u_flag (
            .clk(clk), .rst(rst), .upd_stb(upd_stb), .hit(hit[k]),
            .touched(touched[k]), .set_evt(set_evt[k]), .flag(flag[k])
        );
    end

    pulse_timer #(.TICKS(PULSE_TICKS)) u_pulse (
        .clk(clk), .rst(rst),
        .start(set_evt[1] && irq_en[1]),
        .tick(tick_32k),
        .active(pulse_on)
    );

    assign status = {{(BYTE_W-NUM_ALARMS){1'b0}}, flag};
    assign irq0_n = ~(flag[0] & irq_en[0]);
    assign irq1   = pulse_on & irq_en[1];

    // R6: the level interrupt is asserted only with its flag and enable
    p_irq0_level_r6: assert property (@(posedge clk) disable iff (rst)
        !irq0_n |-> (status[0] && irq_en[0]));

    // R9: a disabled pulse output stays low
    p_irq1_gated_r9: assert property (@(posedge clk) disable iff (rst)
        !irq_en[1] |-> !irq1);

    // R9: no pulse starts from a set seen while disabled
    p_no_start_off_r9: assert property (@(posedge clk) disable iff (rst)
        (!pulse_on && !(set_evt[1] && irq_en[1])) |=> !pulse_on);

endmodule

// File: tb/tb_dual_alarm_irq.sv
module tb_dual_alarm_irq;

    localparam int PT = 2048;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic upd_stb = 1'b0, tick_32k = 1'b1;
    logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_day = '0;
    logic acc_valid = 1'b0;
    logic [7:0] acc_addr = '0, acc_data = '0;
    logic [1:0] irq_en = '0;
    logic [7:0] status;
    logic irq0_n, irq1;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dual_alarm_irq #(.PULSE_TICKS(PT)) dut (
        .clk(clk), .rst(rst), .upd_stb(upd_stb), .tick_32k(tick_32k),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_day(now_day),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_data(acc_data),
        .irq_en(irq_en), .status(status), .irq0_n(irq0_n), .irq1(irq1)
    );

    // {alarm sec,min,hour,day}, {time sec,min,hour,day}, expected flag
    localparam logic [64:0] VEC [9] = '{
        {32'h30150803, 32'h30150803, 1'b1},   // weekly, all equal
        {32'h30150803, 32'h30150804, 1'b0},   // day differs
        {32'h30150883, 32'h30150805, 1'b1},   // daily
        {32'h30158883, 32'h30151105, 1'b1},   // hourly
        {32'h30158883, 32'h31151105, 1'b0},   // hourly, seconds differ
        {32'h30958883, 32'h30421105, 1'b1},   // per minute
        {32'hB0958883, 32'h59421105, 1'b1},   // every second
        {32'h45000000, 32'h45000001, 1'b0},   // unmasked, day differs
        {32'h30155203, 32'h30151203, 1'b0}    // 12/24 bit takes part
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic access(input logic [7:0] a, input logic [7:0] d, input logic stb);
        acc_valid = 1'b1; acc_addr = a; acc_data = d; upd_stb = stb;
        @(negedge clk);
        acc_valid = 1'b0; upd_stb = 1'b0;
    endtask

    task automatic strobe();
        upd_stb = 1'b1;
        @(negedge clk);
        upd_stb = 1'b0;
    endtask

    task automatic load_alarm(input logic [7:0] base, input logic [31:0] v);
        access(8'h80 | base,        v[31:24], 1'b0);
        access(8'h80 | (base + 1),  v[23:16], 1'b0);
        access(8'h80 | (base + 2),  v[15:8],  1'b0);
        access(8'h80 | (base + 3),  v[7:0],   1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int hi;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk("R10 status", status, 8'h00);
        chk("R10 irq0_n", irq0_n, 1);
        chk("R10 irq1", irq1, 0);

        // R1/R2/R3: mask vectors on alarm 0
        foreach (VEC[i]) begin
            load_alarm(8'h07, VEC[i][64:33]);
            {now_sec, now_min, now_hour, now_day} = VEC[i][32:1];
            strobe();
            chk($sformatf("R2 vec%0d flag0", i), status[0], VEC[i][0]);
            chk($sformatf("R3 vec%0d flag1/upper", i), status[7:1], 0);
        end

        // R3: standing match without strobe sets nothing
        load_alarm(8'h07, 32'h80808080);
        repeat (10) @(negedge clk);
        chk("R3 no strobe", status, 8'h00);
        strobe();
        chk("R3 strobe sets bit0", status, 8'h01);

        // R4: clear only by own window
        access(8'h0C, 8'h00, 1'b0);
        chk("R4 other alarm read keeps", status, 8'h01);
        access(8'h10, 8'h00, 1'b0);
        chk("R4 status addr keeps", status, 8'h01);
        access(8'h09, 8'h00, 1'b0);
        chk("R4 read clears", status, 8'h00);
        strobe();
        access(8'h88, 8'h80, 1'b0);
        chk("R4 write clears", status, 8'h00);

        // R5: set and clear in one cycle
        access(8'h07, 8'h00, 1'b1);
        chk("R5 set wins", status, 8'h01);

        // R6: level interrupt gating
        irq_en = 2'b01;
        @(negedge clk);
        chk("R6 irq0 asserted", irq0_n, 0);
        irq_en = 2'b00;
        @(negedge clk);
        chk("R6 irq0 disabled", irq0_n, 1);
        irq_en = 2'b01;
        access(8'h0A, 8'h00, 1'b0);
        chk("R6 irq0 released on clear", irq0_n, 1);
        irq_en = 2'b00;

        // R7/R8: pulse length and no retrigger
        load_alarm(8'h0B, 32'h80808080);
        irq_en = 2'b10;
        strobe();
        hi = 0;
        for (int i = 0; i < 3000; i++) begin
            if (irq1) hi++;
            if (i == 100) begin acc_valid = 1'b1; acc_addr = 8'h0B; end
            if (i == 101) begin acc_valid = 1'b0; upd_stb = 1'b1; end
            if (i == 102) upd_stb = 1'b0;
            @(negedge clk);
        end
        chk("R7 pulse length", hi, PT);
        chk("R8 re-match set flag1", status[1], 1);
        chk("R8 pulse not restarted", irq1, 0);

        // R9: disabled output, no pulse start
        irq_en = 2'b00;
        access(8'h0E, 8'h00, 1'b0);
        strobe();
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            if (irq1) hi++;
            @(negedge clk);
        end
        chk("R9 irq1 held low", hi, 0);
        chk("R9 flag1 still set", status[1], 1);
        irq_en = 2'b10;
        @(negedge clk);
        chk("R9 no late pulse", irq1, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule